// File: doc/BRIEF.md
# Reservation Station Pool

This block is a small pool of waiting slots that sits in front of one execution unit of a speculative out-of-order core. Each dispatched operation carries an operation code, a destination tag (its reorder-buffer slot) and two sources. A source arrives either as a value or as the tag of the operation that will produce it. Slots that are missing a source watch a single result bus for that tag and take the value when it appears. Once both sources are present, a slot is eligible to go to the execution unit. One operation goes each cycle, and the one dispatched earliest goes first. The execution unit is a fixed-latency stub. Its result goes back out on the same bus as a tag/value pair. A slot returns to the pool when its own destination tag is broadcast. A flush empties the pool and drops anything in flight.

Each slot is a four-state machine:
- ST_FREE: empty.
- ST_WAIT: holds at least one producer tag.
- ST_READY: both values are present.
- ST_ISSUED: sent to the unit, waiting for its result.

The named transitions are:
- *alloc-ready*: FREE to READY.
- *alloc-wait*: FREE to WAIT.
- *wakeup*: WAIT to READY.
- *select*: READY to ISSUED.
- *retire*: ISSUED to FREE when its destination tag is seen on the bus.
- *flush*: any state to FREE.

The bus carries the unit's own result when there is one. In any other cycle it carries the external broadcast input, which models the other units.

Top module: `resv_station_pool`

## Requirements
- R1: `disp_accept` is 1 exactly when `disp_valid`, `rob_free` and at least one free slot are all present and `flush` is low. Otherwise dispatch stalls and nothing is written.
- R2: A source marked ready is stored as the supplied value. A source not marked ready is stored as a producer tag, and its supplied value is ignored. A slot holding a tag does not issue.
- R3: A bus broadcast whose tag equals a waiting source tag writes the bus value into that source.
- R4: If the bus carries a source's producer tag in the same cycle that the slot is written at dispatch, the bus value is captured.
- R5: A slot issues only when both values are present. The result is a op b on 16 bits, with op 0=a+b, 1=a-b, 2=a AND b, 3=a XOR b. It appears on the bus with the destination tag FU_LAT=2 cycles after the issue cycle. `issue_valid`/`issue_tag` show the selected slot in the cycle it is selected.
- R6: At most one slot issues per cycle. Among ready slots, the one dispatched earliest issues first, whatever its slot index.
- R7: An issued slot becomes free in the cycle after its destination tag is broadcast, and can then accept a new dispatch.
- R8: A `flush` frees every slot in one cycle and cancels every result still inside the execution unit.
- R9: When the unit produces a result, it takes the bus. An external broadcast in that cycle is dropped and wakes nothing.
- R10: After reset, all slots are free, `issue_valid` is 0 and `cdb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Misprediction flush |
| disp_valid | input | 1 | Dispatch request |
| rob_free | input | 1 | A reorder-buffer slot is free |
| disp_op | input | 2 | Operation code |
| disp_dst | input | TAG_W | Destination tag |
| src_a_ready | input | 1 | Source A is a value |
| src_a_value | input | DATA_W | Source A value |
| src_a_tag | input | TAG_W | Source A producer tag |
| src_b_ready | input | 1 | Source B is a value |
| src_b_value | input | DATA_W | Source B value |
| src_b_tag | input | TAG_W | Source B producer tag |
| ext_bc_valid | input | 1 | External broadcast present |
| ext_bc_tag | input | TAG_W | External broadcast tag |
| ext_bc_value | input | DATA_W | External broadcast value |
| disp_accept | output | 1 | Dispatch taken this cycle |
| issue_valid | output | 1 | A slot is selected this cycle |
| issue_tag | output | TAG_W | Destination tag of the selected slot |
| cdb_valid | output | 1 | Result bus valid |
| cdb_tag | output | TAG_W | Result bus tag |
| cdb_value | output | DATA_W | Result bus value |

## Verification
The main function is swept across all four operations, six operand pairs that include carry, borrow and sign-bit cases, and four source patterns: both sources ready, A waiting, B waiting, and both waiting on different tags. This separates values taken at dispatch from values taken off the bus, and in the pending patterns the dispatched values are deliberately wrong so that a slot which wrongly keeps them gives a bad result. A collision case places an external broadcast in the cycle the unit's result owns the bus, then later sends the same tag with a different value, so the result shows which broadcast was captured. The ordering case refills a low-index slot after two higher ones, so oldest-first and lowest-index selection give different issue orders.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    localparam int OP_W = 2;

    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_READY  = 2'd2,
        ST_ISSUED = 2'd3
    } ent_state_e;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } fu_op_e;
endpackage

// File: rtl/rsp_entry.sv
module rsp_entry
    import rsp_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [OP_W-1:0]   wr_op,
    input  logic [TAG_W-1:0]  wr_dst,
    input  logic              wr_a_rdy,
    input  logic [DATA_W-1:0] wr_a_val,
    input  logic [TAG_W-1:0]  wr_a_tag,
    input  logic              wr_b_rdy,
    input  logic [DATA_W-1:0] wr_b_val,
    input  logic [TAG_W-1:0]  wr_b_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              grant,
    output ent_state_e        state,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    ent_state_e        st_q, st_d;
    logic              a_have_q, b_have_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;

    // source resolution at dispatch (bus snoop in the write cycle)
    logic a_hit_wr, b_hit_wr, a_now_wr, b_now_wr;
    // source resolution while waiting
    logic a_hit_w, b_hit_w, a_now_w, b_now_w;

    assign a_hit_wr = bc_valid && (bc_tag == wr_a_tag);
    assign b_hit_wr = bc_valid && (bc_tag == wr_b_tag);
    assign a_now_wr = wr_a_rdy || a_hit_wr;
    assign b_now_wr = wr_b_rdy || b_hit_wr;
    assign a_hit_w  = bc_valid && !a_have_q && (bc_tag == a_tag_q);
    assign b_hit_w  = bc_valid && !b_have_q && (bc_tag == b_tag_q);
    assign a_now_w  = a_have_q || a_hit_w;
    assign b_now_w  = b_have_q || b_hit_w;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FREE:   if (wr_en) st_d = (a_now_wr && b_now_wr) ? ST_READY : ST_WAIT;
            ST_WAIT:   if (a_now_w && b_now_w) st_d = ST_READY;
            ST_READY:  if (grant) st_d = ST_ISSUED;
            ST_ISSUED: if (bc_valid && (bc_tag == dst_q)) st_d = ST_FREE;
            default:   st_d = ST_FREE;
        endcase
        if (flush) st_d = ST_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            dst_q    <= '0;
            a_have_q <= 1'b0;
            b_have_q <= 1'b0;
            a_tag_q  <= '0;
            b_tag_q  <= '0;
            a_val_q  <= '0;
            b_val_q  <= '0;
        end else if (st_q == ST_FREE && wr_en) begin
            op_q     <= wr_op;
            dst_q    <= wr_dst;
            a_have_q <= a_now_wr;
            b_have_q <= b_now_wr;
            a_tag_q  <= wr_a_tag;
            b_tag_q  <= wr_b_tag;
            a_val_q  <= wr_a_rdy ? wr_a_val : bc_val;
            b_val_q  <= wr_b_rdy ? wr_b_val : bc_val;
        end else if (st_q == ST_WAIT) begin
            if (a_hit_w) begin
                a_have_q <= 1'b1;
                a_val_q  <= bc_val;
            end
            if (b_hit_w) begin
                b_have_q <= 1'b1;
                b_val_q  <= bc_val;
            end
        end
    end

    assign state = st_q;
    assign op    = op_q;
    assign dst   = dst_q;
    assign a_val = a_val_q;
    assign b_val = b_val_q;
endmodule

// File: rtl/rsp_age_pick.sv
module rsp_age_pick #(
    parameter int NUM_ENT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] alloc_oh,
    input  logic [NUM_ENT-1:0] ready,
    output logic [NUM_ENT-1:0] grant
);
    // older_q[i][j] = 1 : slot j was written before slot i
    logic [NUM_ENT-1:0] older_q [NUM_ENT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_ENT; i++) begin
                for (int j = 0; j < NUM_ENT; j++) begin
                    if (alloc_oh[i])      older_q[i][j] <= (i != j);
                    else if (alloc_oh[j]) older_q[i][j] <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_pick
        assign grant[g] = ready[g] && ((ready & older_q[g]) == '0);
    end
endmodule

// File: rtl/rsp_fu_stub.sv
module rsp_fu_stub
    import rsp_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_val
);
    logic [DATA_W-1:0] res;
    logic [LAT-1:0]    stg_v;
    logic [TAG_W-1:0]  stg_tag [LAT];
    logic [DATA_W-1:0] stg_val [LAT];

    always_comb begin
        unique case (fu_op_e'(in_op))
            OP_ADD:  res = in_a + in_b;
            OP_SUB:  res = in_a - in_b;
            OP_AND:  res = in_a & in_b;
            OP_XOR:  res = in_a ^ in_b;
            default: res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= '0;
            for (int s = 0; s < LAT; s++) begin
                stg_tag[s] <= '0;
                stg_val[s] <= '0;
            end
        end else begin
            for (int s = LAT - 1; s > 0; s--) begin
                stg_v[s]   <= stg_v[s-1] & ~flush;
                stg_tag[s] <= stg_tag[s-1];
                stg_val[s] <= stg_val[s-1];
            end
            stg_v[0]   <= in_valid & ~flush;
            stg_tag[0] <= in_tag;
            stg_val[0] <= res;
        end
    end

    assign out_valid = stg_v[LAT-1];
    assign out_tag   = stg_tag[LAT-1];
    assign out_val   = stg_val[LAT-1];
endmodule

// File: rtl/resv_station_pool.sv
module resv_station_pool
    import rsp_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 3,
    parameter int DATA_W  = 16,
    parameter int FU_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    input  logic              rob_free,
    input  logic [1:0]        disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic              src_a_ready,
    input  logic [DATA_W-1:0] src_a_value,
    input  logic [TAG_W-1:0]  src_a_tag,
    input  logic              src_b_ready,
    input  logic [DATA_W-1:0] src_b_value,
    input  logic [TAG_W-1:0]  src_b_tag,
    input  logic              ext_bc_valid,
    input  logic [TAG_W-1:0]  ext_bc_tag,
    input  logic [DATA_W-1:0] ext_bc_value,
    output logic              disp_accept,
    output logic              issue_valid,
    output logic [TAG_W-1:0]  issue_tag,
    output logic              cdb_valid,
    output logic [TAG_W-1:0]  cdb_tag,
    output logic [DATA_W-1:0] cdb_value
);
    localparam int SEL_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    ent_state_e         ent_st  [NUM_ENT];
    logic [OP_W-1:0]    ent_op  [NUM_ENT];
    logic [TAG_W-1:0]   ent_dst [NUM_ENT];
    logic [DATA_W-1:0]  ent_a   [NUM_ENT];
    logic [DATA_W-1:0]  ent_b   [NUM_ENT];
    logic [NUM_ENT-1:0] ent_free, ent_ready, ent_issued;
    logic [NUM_ENT-1:0] pick_oh, alloc_oh, grant;
    logic [SEL_W-1:0]   sel_idx;

    logic              fu_v;
    logic [TAG_W-1:0]  fu_tag;
    logic [DATA_W-1:0] fu_val;

    // result bus: own unit first, external producers otherwise
    assign cdb_valid = fu_v || ext_bc_valid;
    assign cdb_tag   = fu_v ? fu_tag : ext_bc_tag;
    assign cdb_value = fu_v ? fu_val : ext_bc_value;

    // lowest-index free slot
    always_comb begin
        logic found;
        found   = 1'b0;
        pick_oh = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (ent_free[i] && !found) begin
                pick_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign disp_accept = disp_valid && rob_free && !flush && (|ent_free);
    assign alloc_oh    = disp_accept ? pick_oh : '0;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        rsp_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (alloc_oh[g]),
            .wr_op    (disp_op),
            .wr_dst   (disp_dst),
            .wr_a_rdy (src_a_ready),
            .wr_a_val (src_a_value),
            .wr_a_tag (src_a_tag),
            .wr_b_rdy (src_b_ready),
            .wr_b_val (src_b_value),
            .wr_b_tag (src_b_tag),
            .bc_valid (cdb_valid),
            .bc_tag   (cdb_tag),
            .bc_val   (cdb_value),
            .grant    (grant[g]),
            .state    (ent_st[g]),
            .op       (ent_op[g]),
            .dst      (ent_dst[g]),
            .a_val    (ent_a[g]),
            .b_val    (ent_b[g])
        );
        assign ent_free[g]   = (ent_st[g] == ST_FREE);
        assign ent_ready[g]  = (ent_st[g] == ST_READY);
        assign ent_issued[g] = (ent_st[g] == ST_ISSUED);
    end

    rsp_age_pick #(.NUM_ENT(NUM_ENT)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_oh (alloc_oh),
        .ready    (ent_ready),
        .grant    (grant)
    );

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (grant[i]) sel_idx = SEL_W'(i);
        end
    end

    assign issue_valid = |grant;
    assign issue_tag   = ent_dst[sel_idx];

    rsp_fu_stub #(.TAG_W(TAG_W), .DATA_W(DATA_W), .LAT(FU_LAT)) u_fu (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .in_valid  (issue_valid),
        .in_op     (ent_op[sel_idx]),
        .in_a      (ent_a[sel_idx]),
        .in_b      (ent_b[sel_idx]),
        .in_tag    (ent_dst[sel_idx]),
        .out_valid (fu_v),
        .out_tag   (fu_tag),
        .out_val   (fu_val)
    );
endmodule

// File: rtl/resv_station_pool_chk.sv
module resv_station_pool_chk #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               disp_accept,
    input logic               cdb_valid,
    input logic [TAG_W-1:0]   cdb_tag,
    input logic               fu_v,
    input logic [NUM_ENT-1:0] grant,
    input logic [NUM_ENT-1:0] ent_free,
    input logic [NUM_ENT-1:0] ent_ready,
    input logic [NUM_ENT-1:0] ent_issued,
    input logic [TAG_W-1:0]   ent_dst [NUM_ENT]
);
    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R6
    AST_ISSUE_NEEDS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~ent_ready) == '0); // R5
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n) (ent_free == '0) |-> !disp_accept); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (&ent_free)); // R8
    AST_FLUSH_CANCELS: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !fu_v); // R8

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ret
        AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_issued[g] && cdb_valid && cdb_tag == ent_dst[g]) |=> ent_free[g]); // R7
    end
endmodule

bind resv_station_pool resv_station_pool_chk #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .disp_accept (disp_accept),
    .cdb_valid   (cdb_valid),
    .cdb_tag     (cdb_tag),
    .fu_v        (fu_v),
    .grant       (grant),
    .ent_free    (ent_free),
    .ent_ready   (ent_ready),
    .ent_issued  (ent_issued),
    .ent_dst     (ent_dst)
);

// File: tb/tb_resv_station_pool.sv
module tb_resv_station_pool;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic        rob_free = 1'b1;
    logic [1:0]  disp_op = '0;
    logic [2:0]  disp_dst = '0;
    logic        src_a_ready = 1'b0, src_b_ready = 1'b0;
    logic [15:0] src_a_value = '0, src_b_value = '0;
    logic [2:0]  src_a_tag = '0, src_b_tag = '0;
    logic        ext_bc_valid = 1'b0;
    logic [2:0]  ext_bc_tag = '0;
    logic [15:0] ext_bc_value = '0;
    logic        disp_accept, issue_valid, cdb_valid;
    logic [2:0]  issue_tag, cdb_tag;
    logic [15:0] cdb_value;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    resv_station_pool #(.NUM_ENT(4), .TAG_W(3), .DATA_W(16), .FU_LAT(2)) dut (.*);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            0:       return a + b;
            1:       return a - b;
            2:       return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic disp(input int op, input logic [2:0] dst,
                        input bit ar, input logic [15:0] av, input logic [2:0] at,
                        input bit br, input logic [15:0] bv, input logic [2:0] bt);
        disp_valid = 1'b1; disp_op = 2'(op); disp_dst = dst;
        src_a_ready = ar; src_a_value = av; src_a_tag = at;
        src_b_ready = br; src_b_value = bv; src_b_tag = bt;
    endtask

    task automatic disp_off();
        disp_valid = 1'b0;
    endtask

    task automatic bc(input logic [2:0] t, input logic [15:0] v);
        ext_bc_valid = 1'b1; ext_bc_tag = t; ext_bc_value = v;
    endtask

    task automatic bc_off();
        ext_bc_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] va [6] = '{16'h0000, 16'hffff, 16'h1234, 16'h8000, 16'ha5a5, 16'h0007};
        logic [15:0] vb [6] = '{16'h0000, 16'h0001, 16'h0f0f, 16'h8000, 16'h5a5a, 16'h0009};
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R10 reset state
        chk(issue_valid == 1'b0, "R10 issue idle", issue_valid, 0);
        chk(cdb_valid == 1'b0, "R10 bus idle", cdb_valid, 0);
        disp(0, 0, 1, 0, 0, 1, 0, 0);
        #1;
        chk(disp_accept == 1'b1, "R10 slots free", disp_accept, 1);
        disp_off();
        cyc();

        // R2 R3 R5: sweep over ops, operand pairs, source patterns
        for (int op = 0; op < 4; op++) begin
            for (int p = 0; p < 6; p++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [2:0] dst, w1, w2;
                    bit ar, br;
                    logic [15:0] exp;
                    dst = 3'((op * 24 + p * 4 + m) % 8);
                    w1 = dst + 3'd3;
                    w2 = dst + 3'd5;
                    ar = (m == 0 || m == 2);
                    br = (m == 0 || m == 1);
                    exp = model(op, va[p], vb[p]);
                    disp(op, dst, ar, ar ? va[p] : ~va[p], w1, br, br ? vb[p] : ~vb[p], w2);
                    cyc();
                    disp_off();
                    if (m != 0) begin
                        chk(issue_valid == 1'b0, "R2 waits on tag", issue_valid, 0);
                        if (!ar) begin
                            bc(w1, va[p]);
                            cyc();
                            bc_off();
                        end
                        if (m == 3) chk(issue_valid == 1'b0, "R2 one source missing", issue_valid, 0);
                        if (!br) begin
                            bc(w2, vb[p]);
                            cyc();
                            bc_off();
                        end
                    end
                    chk(issue_valid && issue_tag == dst, "R3 wakeup and select", {issue_valid, issue_tag}, {1'b1, dst});
                    cyc();
                    cyc();
                    chk(cdb_valid && cdb_tag == dst && cdb_value == exp, "R5 result on bus",
                        {cdb_valid, cdb_tag, cdb_value}, {1'b1, dst, exp});
                    cyc();
                end
            end
        end

        // R4 same-cycle capture at dispatch
        disp(0, 5, 0, 16'hdead, 6, 1, 16'h0100, 0);
        bc(6, 16'h0023);
        cyc();
        disp_off(); bc_off();
        chk(issue_valid && issue_tag == 3'd5, "R4 captured at dispatch", {issue_valid, issue_tag}, {1'b1, 3'd5});
        cyc(); cyc();
        chk(cdb_valid && cdb_value == 16'h0123, "R4 captured value", cdb_value, 16'h0123);
        cyc(); cyc();

        // R9 bus priority: external broadcast dropped under own result
        disp(0, 1, 1, 16'd10, 0, 1, 16'd3, 0);
        cyc();
        disp(1, 2, 0, 16'h0, 5, 1, 16'd4, 0);
        cyc();
        disp_off();
        cyc();
        bc(5, 16'd100);
        chk(cdb_valid && cdb_tag == 3'd1 && cdb_value == 16'd13, "R9 own result owns bus", {cdb_tag, cdb_value}, {3'd1, 16'd13});
        cyc();
        bc_off();
        chk(issue_valid == 1'b0, "R9 dropped broadcast no wakeup", issue_valid, 0);
        cyc();
        chk(issue_valid == 1'b0, "R9 still waiting", issue_valid, 0);
        bc(5, 16'd200);
        cyc();
        bc_off();
        chk(issue_valid && issue_tag == 3'd2, "R9 later broadcast wakes", {issue_valid, issue_tag}, {1'b1, 3'd2});
        cyc(); cyc();
        chk(cdb_valid && cdb_value == 16'd196, "R9 later value used", cdb_value, 16'd196);
        cyc(); cyc();

        // R6 oldest first, slot 0 refilled last
        disp(0, 0, 1, 16'd1, 0, 1, 16'd1, 0);
        cyc();
        disp(0, 1, 0, 16'h0, 7, 1, 16'd1, 0);
        cyc();
        disp(0, 2, 0, 16'h0, 7, 1, 16'd2, 0);
        cyc();
        disp_off();
        cyc();
        disp(0, 3, 0, 16'h0, 7, 1, 16'd3, 0);
        cyc();
        disp_off();
        bc(7, 16'h0011);
        cyc();
        bc_off();
        chk(issue_valid && issue_tag == 3'd1, "R6 oldest first", issue_tag, 1);
        cyc();
        chk(issue_valid && issue_tag == 3'd2, "R6 second oldest", issue_tag, 2);
        cyc();
        chk(issue_valid && issue_tag == 3'd3, "R6 youngest last", issue_tag, 3);
        repeat (6) cyc();

        // R1 fill and stall, R8 flush of waiting slots
        for (int k = 0; k < 4; k++) begin
            disp(0, 3'(k), 0, 16'h0, 7, 0, 16'h0, 7);
            #1;
            chk(disp_accept == 1'b1, "R1 accept while free", disp_accept, 1);
            cyc();
        end
        disp(0, 4, 1, 16'h0, 0, 1, 16'h0, 0);
        #1;
        chk(disp_accept == 1'b0, "R1 stall when full", disp_accept, 0);
        disp_off();
        flush = 1'b1;
        cyc();
        flush = 1'b0;
        bc(7, 16'h0005);
        cyc();
        bc_off();
        chk(issue_valid == 1'b0, "R8 flushed slots ignore wakeup", issue_valid, 0);
        cyc();
        chk(cdb_valid == 1'b0, "R8 no result after flush", cdb_valid, 0);
        rob_free = 1'b0;
        disp(0, 4, 1, 16'h0, 0, 1, 16'h0, 0);
        #1;
        chk(disp_accept == 1'b0, "R1 stall without reorder slot", disp_accept, 0);
        rob_free = 1'b1;
        #1;
        chk(disp_accept == 1'b1, "R8 pool empty after flush", disp_accept, 1);
        disp_off();

        // R7 slots reusable after their results return
        for (int k = 0; k < 4; k++) begin
            disp(3, 3'(k), 1, 16'h00f0, 0, 1, 16'h000f, 0);
            #1;
            chk(disp_accept == 1'b1, "R7 fill ready", disp_accept, 1);
            cyc();
        end
        disp_off();
        repeat (8) cyc();
        for (int k = 0; k < 4; k++) begin
            disp(0, 3'(k + 4), 0, 16'h0, 6, 0, 16'h0, 6);
            #1;
            chk(disp_accept == 1'b1, "R7 slot freed by retire", disp_accept, 1);
            cyc();
        end
        disp_off();
        flush = 1'b1;
        cyc();
        flush = 1'b0;

        // R8 in-flight result cancelled
        disp(0, 4, 1, 16'd1, 0, 1, 16'd2, 0);
        cyc();
        disp_off();
        cyc();
        flush = 1'b1;
        cyc();
        flush = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(cdb_valid == 1'b0, "R8 in-flight cancelled", cdb_valid, 0);
            cyc();
        end

        summary();
        $finish;
    end
endmodule